// File: doc/BRIEF.md
# Sweeping Three-Light Eye Sequencer

This block drives three lamp outputs, one at each end of a row and one in the centre. Exactly one lamp is lit at any moment. The lit spot travels from the left end to the right end and then back to the left, and it repeats this for as long as the block runs.

The machine is a Moore machine, so the lamps depend only on the current state. The centre lamp is lit on the way out and again on the way back. Those two visits are separate states, so three lamps need four states.

The block has no data inputs. A step-enable input sets the rate of the sweep. That input can advance the sequence directly, or it can pass through a built-in divider so that only every N-th asserted cycle advances it. A parameter chooses between these two variants when the block is built.

Top module: `eye_sweep_top`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, only `lamp_left` is high.
- R2: In every cycle after reset, exactly one of `lamp_left`, `lamp_mid` and `lamp_right` is high.
- R3: Each advance moves the spot one position along the cyclic order left, centre (outbound), right, centre (return), back to left. The sequence therefore has a period of four advances.
- R4: In a cycle with no advance, all three lamp outputs keep their values.
- R5: When `USE_DIVIDER` is 1, an advance happens only on the `DIV_RATIO`-th cycle in which `step_en` is high. Cycles with `step_en` low neither advance the sweep nor count toward the ratio. There is never an advance without `step_en`.
- R6: When `USE_DIVIDER` is 0, every clock edge that samples `step_en` high advances the sweep by one position.
- R7: Asserting reset in the middle of a sweep returns the spot to the left lamp. It also clears any partial divider count, so the next advance needs a full `DIV_RATIO` high cycles.
- R8: From the centre lamp, the next advance goes right if the last end lamp lit was the left one. It goes left if the last end lamp lit was the right one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | Step-enable; an advance request, or a count pulse for the divider |
| lamp_left | output | 1 | High when the left lamp is on |
| lamp_mid | output | 1 | High when the centre lamp is on |
| lamp_right | output | 1 | High when the right lamp is on |

## Verification
The bench builds two copies of the block side by side. One is the direct variant (`USE_DIVIDER` = 0), where one tick is one step. This lets a short table walk the full four-step period twice, with idle cycles placed among the steps. The other uses the divider with `DIV_RATIO` = 3. A ratio this small makes it cheap to reach a partial count broken by idle cycles, and a partial count wiped by a reset in mid-sweep.

// File: rtl/eye_sweep_pkg.sv
package eye_sweep_pkg;

  typedef enum logic [1:0] {
    EYE_LEFT     = 2'd0,
    EYE_MID_OUT  = 2'd1,
    EYE_RIGHT    = 2'd2,
    EYE_MID_BACK = 2'd3
  } eye_pos_e;

  typedef struct packed {
    logic left;
    logic mid;
    logic right;
  } lamp_set_t;

  function automatic eye_pos_e eye_next(input eye_pos_e cur);
    eye_pos_e nxt;
    case (cur)
      EYE_LEFT:     nxt = EYE_MID_OUT;
      EYE_MID_OUT:  nxt = EYE_RIGHT;
      EYE_RIGHT:    nxt = EYE_MID_BACK;
      EYE_MID_BACK: nxt = EYE_LEFT;
      default:      nxt = EYE_LEFT;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/eye_step_divider.sv
module eye_step_divider #(
  parameter int unsigned RATIO = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_in,
  output logic tick
);
  localparam int unsigned CW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] cnt;

  assign tick = step_in && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (step_in) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/eye_sweep_fsm.sv
module eye_sweep_fsm
  import eye_sweep_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     adv,
  output eye_pos_e pos
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= EYE_LEFT;
    end else if (adv) begin
      pos <= eye_next(pos);
    end
  end
endmodule

// File: rtl/eye_lamp_decode.sv
module eye_lamp_decode
  import eye_sweep_pkg::*;
(
  input  eye_pos_e  pos,
  output lamp_set_t lamps
);
  always_comb begin
    lamps = '0;
    case (pos)
      EYE_LEFT:     lamps.left  = 1'b1;
      EYE_MID_OUT:  lamps.mid   = 1'b1;
      EYE_RIGHT:    lamps.right = 1'b1;
      EYE_MID_BACK: lamps.mid   = 1'b1;
      default:      lamps.left  = 1'b1;
    endcase
  end
endmodule

// File: rtl/eye_sweep_top.sv
module eye_sweep_top
  import eye_sweep_pkg::*;
#(
  parameter bit          USE_DIVIDER = 1'b1,
  parameter int unsigned DIV_RATIO   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_en,
  output logic lamp_left,
  output logic lamp_mid,
  output logic lamp_right
);
  logic      adv;
  eye_pos_e  pos;
  lamp_set_t lamps;

  generate
    if (USE_DIVIDER) begin : g_div
      eye_step_divider #(.RATIO(DIV_RATIO)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_in (step_en),
        .tick    (adv)
      );
    end else begin : g_direct
      assign adv = step_en;
    end
  endgenerate

  eye_sweep_fsm u_fsm (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv),
    .pos   (pos)
  );

  eye_lamp_decode u_dec (
    .pos   (pos),
    .lamps (lamps)
  );

  assign lamp_left  = lamps.left;
  assign lamp_mid   = lamps.mid;
  assign lamp_right = lamps.right;
endmodule

// File: rtl/eye_sweep_checker.sv
module eye_sweep_checker (
  input logic clk,
  input logic rst_n,
  input logic step_en,
  input logic adv,
  input logic lamp_left,
  input logic lamp_mid,
  input logic lamp_right
);
  logic last_was_left;

  always_ff @(posedge clk) begin
    if (!rst_n)          last_was_left <= 1'b1;
    else if (lamp_left)  last_was_left <= 1'b1;
    else if (lamp_right) last_was_left <= 1'b0;
  end

  assert_reset_left_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (lamp_left && !lamp_mid && !lamp_right));

  assert_one_lamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({lamp_left, lamp_mid, lamp_right}) == 1);

  assert_left_to_mid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && lamp_left) |=> lamp_mid);

  assert_right_to_mid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && lamp_right) |=> lamp_mid);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(lamp_left) && $stable(lamp_mid) && $stable(lamp_right)));

  assert_tick_needs_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |-> !adv);

  assert_mid_goes_right_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && lamp_mid && last_was_left) |=> lamp_right);

  assert_mid_goes_left_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && lamp_mid && !last_was_left) |=> lamp_left);
endmodule

bind eye_sweep_top eye_sweep_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .step_en    (step_en),
  .adv        (adv),
  .lamp_left  (lamp_left),
  .lamp_mid   (lamp_mid),
  .lamp_right (lamp_right)
);

// File: tb/eye_sweep_top_test.sv
`timescale 1ns/1ps
module eye_sweep_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_a = 1'b0;
  logic step_b = 1'b0;
  logic la, ma, ra, lb, mb, rb;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  eye_sweep_top #(.USE_DIVIDER(1'b0), .DIV_RATIO(4)) uut (
    .clk(clk), .rst_n(rst_n), .step_en(step_a),
    .lamp_left(la), .lamp_mid(ma), .lamp_right(ra)
  );

  eye_sweep_top #(.USE_DIVIDER(1'b1), .DIV_RATIO(3)) uut_div (
    .clk(clk), .rst_n(rst_n), .step_en(step_b),
    .lamp_left(lb), .lamp_mid(mb), .lamp_right(rb)
  );

  // {step, expected left, mid, right} for the direct copy, starting from reset
  localparam logic [3:0] VEC [12] = '{
    4'b1_010, 4'b0_010, 4'b1_001, 4'b1_010, 4'b0_010, 4'b1_100,
    4'b1_010, 4'b1_001, 4'b1_010, 4'b1_100, 4'b0_100, 4'b1_010
  };

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: lamps got %b expected %b", req, got, exp);
    end
  endtask

  // called at a negedge; applies inputs for one edge and returns after it at next negedge
  task automatic cycle(input logic sa, input logic sb);
    step_a = sa;
    step_b = sb;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 direct in reset", {la, ma, ra}, 3'b100);
    check("R1 divided in reset", {lb, mb, rb}, 3'b100);
    @(negedge clk);
    rst_n = 1'b1;
    cycle(1'b0, 1'b0);
    check("R1 first cycle after reset", {la, ma, ra}, 3'b100);
    @(negedge clk);

    // table walk: R3, R4, R6, R8, one-hot R2
    foreach (VEC[i]) begin
      cycle(VEC[i][3], 1'b0);
      check("R3/R6/R8 sweep step", {la, ma, ra}, VEC[i][2:0]);
      check("R2 one lamp", 3'(($countones({la, ma, ra}) == 1) ? 3'b001 : 3'b000), 3'b001);
      @(negedge clk);
    end

    // R4 hold over several idle cycles
    for (int k = 0; k < 3; k++) begin
      cycle(1'b0, 1'b0);
      check("R4 hold while idle", {la, ma, ra}, 3'b010);
      @(negedge clk);
    end

    // R5 divider: two highs, an idle, then third high advances
    cycle(1'b0, 1'b1);
    check("R5 first count", {lb, mb, rb}, 3'b100);
    @(negedge clk);
    cycle(1'b0, 1'b1);
    check("R5 second count", {lb, mb, rb}, 3'b100);
    @(negedge clk);
    cycle(1'b0, 1'b0);
    check("R5 idle does not count", {lb, mb, rb}, 3'b100);
    @(negedge clk);
    cycle(1'b0, 1'b1);
    check("R5 third count advances", {lb, mb, rb}, 3'b010);
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      cycle(1'b0, 1'b1);
      if (k < 2) check("R5 partial count holds", {lb, mb, rb}, 3'b010);
      else       check("R5 R8 advance to right", {lb, mb, rb}, 3'b001);
      @(negedge clk);
    end

    // R7 reset mid sweep clears position and partial count
    cycle(1'b1, 1'b1);
    @(negedge clk);
    cycle(1'b0, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    cycle(1'b0, 1'b0);
    check("R7 direct back to left", {la, ma, ra}, 3'b100);
    check("R7 divided back to left", {lb, mb, rb}, 3'b100);
    @(negedge clk);
    rst_n = 1'b1;
    cycle(1'b0, 1'b1);
    check("R7 count restarted 1", {lb, mb, rb}, 3'b100);
    @(negedge clk);
    cycle(1'b0, 1'b1);
    check("R7 count restarted 2", {lb, mb, rb}, 3'b100);
    @(negedge clk);
    cycle(1'b0, 1'b1);
    check("R7 full count advances", {lb, mb, rb}, 3'b010);
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule